// File: doc/BRIEF.md
# Hex-text word streamer over a serial transmit line

This block takes 32-bit words from the read side of a first-word-fall-through FIFO and turns each one into a line of readable hexadecimal text on a single asynchronous serial transmit wire. A plain serial terminal on the host can then show the values directly, with nothing to decode on the host side. Each word becomes eight hex digits, most significant first, followed by a carriage return and a line feed. Every character is sent as one frame with 8 data bits, no parity and one stop bit.

The producer may keep writing the FIFO while a line is going out. The block reads the FIFO only when the previous line has fully left the wire. The FIFO side follows a valid/ready rule. The FIFO's not-empty state is the valid, the data is already present on `fifo_data`, and `fifo_rd_en` is the ready, a single-cycle accept. Back-pressure toward the FIFO lasts for the whole of a line: the block accepts at most one word per line time and holds `fifo_rd_en` low the rest of the time. The serial wire has no handshake, so nothing can hold the block back once a line has started. The bit rate comes from a clock divider. Its ratio is the system clock frequency over the baud rate, rounded to the nearest integer.

Top module: `hexline_uart_tx`

## Requirements
- R1: Every bit on `tx` lasts exactly DIV clock cycles, where DIV = round(CLK_HZ / BAUD), computed as (CLK_HZ + BAUD/2) / BAUD. At 1 MHz and 115200 baud this gives DIV = 9, not the truncated 8.
- R2: Each character is one frame, sent in this order: a start bit at 0, then 8 data bits with bit 0 first, then a stop bit at 1.
- R3: Each word is sent as ten characters. The first eight are hex digits, taking bits 31:28 first and bits 3:0 last. Then come 0x0D and 0x0A. The frames of one line follow each other with no idle cycle between them.
- R4: A digit value of 0 to 9 is sent as 0x30 to 0x39. A digit value of 10 to 15 is sent as the uppercase codes 0x41 to 0x46.
- R5: `fifo_rd_en` goes high for exactly one cycle per word, and only while the block is idle and `fifo_empty` is low. The word on `fifo_data` in that cycle is the one sent. The start bit of the first character begins in the next cycle.
- R6: The next word is accepted only after the stop bit of the previous line's line feed has lasted its full DIV cycles. Between two lines, `tx` stays high for DIV + 1 cycles or more.
- R7: While the FIFO is empty and no line is in progress, `tx` stays high and `fifo_rd_en` stays low.
- R8: While `rst_n` is low, `tx` is high and `fifo_rd_en` is low, even when the FIFO holds data. Reset acts asynchronously.
- R9: Words written while a line is being sent are all sent later, in the order they were written, with none lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low, idles high |
| fifo_data | input | WORD_W | Head word of the first-word-fall-through FIFO |
| fifo_empty | input | 1 | High when the FIFO holds no word |
| fifo_rd_en | output | 1 | One-cycle pulse that pops the head word |
| tx | output | 1 | Serial transmit line, idles high |

## Verification
The assertions check, on every clock, the following properties: the line stays high whenever no frame is active; a level changes only at a bit boundary or at a frame load; a new frame loads only when none is running or one has just ended; the read pulse lasts a single cycle; and every loaded character is a valid hex digit, CR or LF. Other behaviours depend on a whole sequence of cycles, so only the bench scenarios can show them. These are the exact bit length produced by the rounded divider, the digit order within a line, and the gap between lines. They also include the handling of a FIFO that already holds data during reset, and the ordering of words written while a line is still going out. For these, the bench compares the line against a behavioural model on every cycle and also decodes the frames back into characters.

// File: rtl/hexline_pkg.sv
package hexline_pkg;

  localparam logic [7:0] CH_CR = 8'h0D;
  localparam logic [7:0] CH_LF = 8'h0A;
  localparam int unsigned FRAME_BITS = 10;

  // Digit value to printable uppercase hex code.
  function automatic logic [7:0] nib2ascii(input logic [3:0] n);
    if (n < 4'd10) return 8'h30 + {4'h0, n};
    else           return 8'h37 + {4'h0, n};
  endfunction

endpackage

// File: rtl/hexline_baud.sv
module hexline_baud #(
  parameter int unsigned DIV = 868
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int unsigned CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == CNT_TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (run) begin
      if (cnt == CNT_TOP) cnt <= '0;
      else                cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_TOP); // R1

endmodule

// File: rtl/hexline_serializer.sv
module hexline_serializer #(
  parameter int unsigned DIV = 868
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] byte_in,
  output logic       tx,
  output logic       done
);
  import hexline_pkg::*;

  localparam logic [3:0] LAST_BIT = 4'(FRAME_BITS - 1);

  logic       active;
  logic       tick;
  logic [8:0] shreg;
  logic [3:0] bitcnt;

  hexline_baud #(.DIV(DIV)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .run   (active),
    .tick  (tick)
  );

  assign done = tick && (bitcnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tx     <= 1'b1;
      shreg  <= '1;
      bitcnt <= '0;
    end else if (start) begin
      active <= 1'b1;
      tx     <= 1'b0;
      shreg  <= {1'b1, byte_in};
      bitcnt <= '0;
    end else if (tick) begin
      if (bitcnt == LAST_BIT) begin
        active <= 1'b0;
        tx     <= 1'b1;
      end else begin
        tx     <= shreg[0];
        shreg  <= {1'b1, shreg[8:1]};
        bitcnt <= bitcnt + 1'b1;
      end
    end
  end

  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> tx); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!active || done)); // R6
  AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick && !start) |=> $stable(tx)); // R1
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !tx); // R2

endmodule

// File: rtl/hexline_charseq.sv
module hexline_charseq #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  input  logic              frame_done,
  output logic              start,
  output logic [7:0]        start_byte
);
  import hexline_pkg::*;

  localparam int unsigned NIB   = WORD_W / 4;
  localparam int unsigned CHARS = NIB + 2;
  localparam int unsigned IDX_W = $clog2(CHARS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CHARS - 1);

  logic              busy;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_next;
  logic [WORD_W-1:0] word_q;
  logic [7:0]        line_chars [CHARS];
  logic              advance;

  for (genvar g = 0; g < NIB; g++) begin : g_digit
    assign line_chars[g] = nib2ascii(word_q[WORD_W-1-4*g -: 4]);
  end
  assign line_chars[NIB]     = CH_CR;
  assign line_chars[NIB + 1] = CH_LF;

  assign idx_next   = idx + 1'b1;
  assign fifo_rd_en = rst_n && !busy && !fifo_empty;
  assign advance    = busy && frame_done && (idx != LAST);
  assign start      = fifo_rd_en || advance;
  assign start_byte = fifo_rd_en ? nib2ascii(fifo_data[WORD_W-1 -: 4])
                                 : line_chars[idx_next];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      word_q <= '0;
    end else if (fifo_rd_en) begin
      busy   <= 1'b1;
      idx    <= '0;
      word_q <= fifo_data;
    end else if (busy && frame_done) begin
      if (idx == LAST) busy <= 1'b0;
      else             idx  <= idx_next;
    end
  end

  AST_SINGLE_POP: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |=> !fifo_rd_en); // R5
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (idx <= LAST)); // R3
  AST_CHAR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ((start_byte >= 8'h30 && start_byte <= 8'h39) ||
               (start_byte >= 8'h41 && start_byte <= 8'h46) ||
               start_byte == CH_CR || start_byte == CH_LF)); // R4

endmodule

// File: rtl/hexline_uart_tx.sv
module hexline_uart_tx #(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned BAUD   = 115_200,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_rd_en,
  output logic              tx
);
  localparam int unsigned DIV = (CLK_HZ + BAUD / 2) / BAUD;

  logic       start;
  logic [7:0] start_byte;
  logic       frame_done;

  hexline_charseq #(.WORD_W(WORD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_data  (fifo_data),
    .fifo_empty (fifo_empty),
    .fifo_rd_en (fifo_rd_en),
    .frame_done (frame_done),
    .start      (start),
    .start_byte (start_byte)
  );

  hexline_serializer #(.DIV(DIV)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .byte_in (start_byte),
    .tx      (tx),
    .done    (frame_done)
  );

  AST_POP_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd_en |=> !tx); // R5

endmodule

// File: tb/sim_hexline_uart_tx.sv
module sim_hexline_uart_tx;
  localparam int unsigned CLK_HZ = 1_000_000;
  localparam int unsigned BAUD   = 115_200;
  localparam int DIV = 9; // rounded 8.68, R1

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fifo_data = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_rd_en;
  logic        tx;

  int checks = 0;
  int failures = 0;
  int pops = 0;
  int pushed = 0;

  logic [31:0] q[$];
  logic [31:0] push_q[$];
  logic [7:0]  exp_chars[$];
  bit          line[$];
  bit          m_busy = 0;
  bit          tx_exp = 1;

  always #2.5 clk = ~clk;

  hexline_uart_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .WORD_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_rd_en(fifo_rd_en), .tx(tx)
  );

  function automatic logic [7:0] hexc(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(65 + n - 10);
  endfunction

  function automatic logic [7:0] char_of(input logic [31:0] w, input int c);
    if (c < 8) return hexc(int'((w >> (28 - 4 * c)) & 32'hF));
    return (c == 8) ? 8'h0D : 8'h0A;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic push_word(input logic [31:0] w);
    @(posedge clk); #1;
    push_q.push_back(w);
    pushed++;
    for (int c = 0; c < 10; c++) exp_chars.push_back(char_of(w, c));
  endtask

  // Behavioural reference: FIFO, pop decision and expected line level.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; line.delete(); tx_exp = 1;
    end else if (m_busy) begin
      if (line.size() > 0) tx_exp = line.pop_front();
      else begin m_busy = 0; tx_exp = 1; end
    end else if (q.size() > 0) begin
      logic [31:0] w;
      w = q.pop_front();
      for (int c = 0; c < 10; c++) begin
        logic [7:0] ch;
        ch = char_of(w, c);
        for (int b = 0; b < 10; b++)
          for (int k = 0; k < DIV; k++)
            line.push_back((b == 0) ? 1'b0 : (b == 9) ? 1'b1 : ch[b-1]);
      end
      tx_exp = line.pop_front();
      m_busy = 1;
    end
    while (push_q.size() > 0) q.push_back(push_q.pop_front());
    fifo_empty <= (q.size() == 0);
    fifo_data  <= (q.size() > 0) ? q[0] : 32'h0;
  end

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_rd;
      exp_rd = !m_busy && (q.size() > 0);
      if (!m_busy && q.size() == 0) begin
        check(tx == 1'b1, "R7 idle tx", tx, 1);
        check(fifo_rd_en == 1'b0, "R7 idle rd_en", fifo_rd_en, 0);
      end else begin
        check(tx == tx_exp, "R1 R2 R3 R6 tx level", tx, tx_exp);
        check(fifo_rd_en == exp_rd, "R5 R6 rd_en", fifo_rd_en, exp_rd);
      end
      if (fifo_rd_en) pops++;
    end
  end

  // Frame decoder: samples mid-bit and checks characters in order.
  initial begin
    wait (rst_n);
    forever begin
      logic [7:0] ch;
      logic [7:0] e;
      @(negedge clk);
      if (tx == 1'b0) begin
        repeat (DIV / 2) @(negedge clk);
        check(tx == 1'b0, "R2 start bit", tx, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (DIV) @(negedge clk);
          ch[i] = tx;
        end
        repeat (DIV) @(negedge clk);
        check(tx == 1'b1, "R2 stop bit", tx, 1);
        e = (exp_chars.size() > 0) ? exp_chars.pop_front() : 8'hXX;
        check(ch === e, "R3 R4 R9 character", ch, e);
      end
    end
  end

  task automatic wait_idle(input int limit);
    int n = 0;
    while (!(!m_busy && q.size() == 0 && push_q.size() == 0 && exp_chars.size() == 0)) begin
      @(negedge clk);
      n++;
      if (n > limit) begin
        check(0, "watchdog", n, limit);
        break;
      end
    end
  endtask

  initial begin
    int lowrun;
    // Word present during reset: must not pop, line stays high (R8).
    push_word(32'h1234ABCD);
    repeat (5) begin
      @(negedge clk);
      check(tx == 1'b1, "R8 reset tx", tx, 1);
      check(fifo_rd_en == 1'b0, "R8 reset rd_en", fifo_rd_en, 0);
    end
    @(negedge clk); rst_n = 1'b1;
    // First char '1' = 0x31: start bit alone is low for DIV cycles (R1).
    lowrun = 0;
    while (tx == 1'b1) @(negedge clk);
    while (tx == 1'b0) begin lowrun++; @(negedge clk); end
    check(lowrun == DIV, "R1 rounded bit width", lowrun, DIV);
    wait_idle(5000);
    // Empty FIFO idle stretch (R7).
    repeat (200) @(negedge clk);
    // Back-to-back burst.
    push_word(32'h00000000);
    push_word(32'hFFFFFFFF);
    push_word(32'h89ABCDEF);
    repeat (300) @(negedge clk);
    // Writes while a line is in flight (R9).
    push_word(32'h0F1E2D3C);
    repeat (450) @(negedge clk);
    push_word(32'hA5A55A5A);
    wait_idle(20000);
    repeat (50) @(negedge clk);
    check(pops == pushed, "R5 one pop per word", pops, pushed);
    check(exp_chars.size() == 0, "R3 all characters seen", exp_chars.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule